// File: doc/BRIEF.md
# Serial-Controlled Memory Bus Bridge

This block lets an external controller on a four-wire serial link (SPI mode 0, active-low select) read and write a 128-bit TileLink-UL memory bus. The serial side is a small byte-wide register file. The controller sets up a 32-bit target address and a 16-bit length, then writes a command. The bridge state machine issues exactly one single-beat bus request for that command and captures the response. Read data goes into a 16-byte line buffer, and a byte-serial data port streams that buffer back out.

Writes can be set up in two ways. The controller can fill the line buffer through the data port and then issue a write command. It can also send a packed transfer, which carries the address and a whole line in one frame and starts the write by itself. Reads and writes each report completion in their own status register. After a command completes, the controller must send the null command. This clears the status and makes the bridge ready for the next command.

The serial pins are oversampled in the bus clock through synchronizer chains, so the whole block runs in a single clock domain.

Top module: `spi_tl_bridge`

## Requirements
- R1: After reset, MISO is 0, no bus request is valid, and every register reads 0: the four address bytes, both length bytes, the command byte, read status and write status.
- R2: The bit fields of a serial frame are as follows:
  - Selecting the chip starts the frame.
  - MOSI is sampled on the rising edge of SCK, and MISO changes on the falling edge.
  - The first byte is a header, sent most significant bit first: bit 7 = 1 means write, and bits 6:0 give the register address.
  - Each following byte reads or writes that register, and the address then advances by one.
  - Address bytes sit at 0x00 to 0x03, least significant byte first.
  - Status codes are 0 idle, 1 busy, 2 done and 3 error.
- R3: The length register is at 0x04 (low byte) and 0x05 (high byte) and reads back what was written. Its value does not change the bus request, which is always a single beat of size 4 (16 bytes).
- R4: Writing command 0x01 to register 0x06 issues one Get (opcode 4). The request has size 4, all 16 mask bits set, and the programmed address with bits 3:0 forced to 0.
- R5: While a request is valid and not accepted, it stays valid and its opcode and address do not change.
- R6: A read is answered by AccessAckData (opcode 1) without error. The read status (0x07) then becomes 2 and the line buffer takes the response data. The data port (0x09) does not advance the register address. It returns buffer bytes least significant first, and every header restarts it at byte 0.
- R7: A write frame to 0x0A carries 4 address bytes and then 16 data bytes, each least significant first. Its last byte issues PutFullData (opcode 0) with that line and all mask bits set. An AccessAck (opcode 0) without error sets the write status (0x08) to 2.
- R8: A response with its error bit set, or with an unexpected opcode, sets the status to 3 and leaves the line buffer unchanged.
- R9: When a status is 2 or 3, writing command 0x00 returns both statuses to 0 and lets the bridge accept commands again. Nothing else clears a status.
- R10: The bridge ignores a command that arrives while a request is in flight or before the null command. No further bus request is issued and the statuses do not change.
- R11: Command 0x02 writes the current line buffer, as filled through the data port, to the programmed address with PutFullData.
- R12: At most one request is outstanding, and at most one of the two status registers is non-idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck_i | input | 1 | Serial clock from controller |
| spi_csb_i | input | 1 | Active-low chip select |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| tl_a_valid_o | output | 1 | Request valid |
| tl_a_ready_i | input | 1 | Request accepted |
| tl_a_opcode_o | output | 3 | Request opcode |
| tl_a_size_o | output | 3 | Log2 of transfer bytes |
| tl_a_source_o | output | SRC_W | Request source id |
| tl_a_address_o | output | 32 | Line-aligned bus address |
| tl_a_mask_o | output | LINE_BYTES | Byte lane enables |
| tl_a_data_o | output | 8*LINE_BYTES | Write line |
| tl_d_valid_i | input | 1 | Response valid |
| tl_d_ready_o | output | 1 | Response accepted |
| tl_d_opcode_i | input | 3 | Response opcode |
| tl_d_error_i | input | 1 | Response error flag |
| tl_d_data_i | input | 8*LINE_BYTES | Read line |

## Verification
The assertions check the following on every cycle:
- a held request keeps its opcode and address while it waits;
- at most one status register is non-idle;
- a done read status appears only right after a response handshake;
- a completed status clears only on the null command;
- command and packed-write launches last a single cycle.

The other behaviours show only in the bench scenarios:
- the serial framing and register readback;
- address alignment and full masks on the bus;
- line data matching through packed writes, buffered writes and bulk reads;
- an error response leaving the buffer intact;
- commands ignored while the bridge is busy.

// File: rtl/spi_tl_pkg.sv
package spi_tl_pkg;
    localparam int ADDR_BYTES = 4;

    localparam logic [6:0] REG_ADDR0   = 7'h00;
    localparam logic [6:0] REG_LEN_LO  = 7'h04;
    localparam logic [6:0] REG_LEN_HI  = 7'h05;
    localparam logic [6:0] REG_CMD     = 7'h06;
    localparam logic [6:0] REG_RD_STAT = 7'h07;
    localparam logic [6:0] REG_WR_STAT = 7'h08;
    localparam logic [6:0] REG_DATA    = 7'h09;
    localparam logic [6:0] REG_PACK    = 7'h0A;

    localparam logic [7:0] CMD_NULL  = 8'h00;
    localparam logic [7:0] CMD_READ  = 8'h01;
    localparam logic [7:0] CMD_WRITE = 8'h02;

    localparam logic [2:0] OP_PUT_FULL = 3'd0;
    localparam logic [2:0] OP_GET      = 3'd4;
    localparam logic [2:0] OP_ACK      = 3'd0;
    localparam logic [2:0] OP_ACK_DATA = 3'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_DONE  = 2'd2,
        ST_ERROR = 2'd3
    } stat_e;

    typedef enum logic [1:0] {
        H_IDLE,
        H_REQ,
        H_RESP,
        H_HOLD
    } hstate_e;
endpackage

// File: rtl/spi_tl_shift.sv
// Oversampling serial shifter: synchronizes pins, detects edges, frames bytes.
module spi_tl_shift #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       csb_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_byte_i,
    output logic       miso_o,
    output logic       frame_start_o,
    output logic       byte_done_o,
    output logic [7:0] rx_byte_o
);
    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] sck_sync;
        logic [SW-1:0] cs_sync;
        logic [SW-1:0] mosi_sync;
        logic          sck_prev;
        logic          cs_prev;
        logic [2:0]    bit_cnt;
        logic [7:0]    rx_sh;
        logic [7:0]    tx_sh;
    } sh_t;

    sh_t q, d;
    logic sck_s, cs_s, mosi_s, rise, fall;
    logic [7:0] rx_full;

    always_comb begin
        d      = q;
        sck_s  = q.sck_sync[SW-1];
        cs_s   = q.cs_sync[SW-1];
        mosi_s = q.mosi_sync[SW-1];
        d.sck_sync  = {q.sck_sync[SW-2:0], sck_i};
        d.cs_sync   = {q.cs_sync[SW-2:0], csb_i};
        d.mosi_sync = {q.mosi_sync[SW-2:0], mosi_i};
        d.sck_prev  = sck_s;
        d.cs_prev   = cs_s;
        rise    = sck_s & ~q.sck_prev & ~cs_s;
        fall    = ~sck_s & q.sck_prev & ~cs_s;
        rx_full = {q.rx_sh[6:0], mosi_s};
        frame_start_o = ~cs_s & q.cs_prev;
        byte_done_o   = rise && (q.bit_cnt == 3'd7);
        rx_byte_o     = rx_full;
        if (frame_start_o) begin
            d.bit_cnt = 3'd0;
            d.rx_sh   = 8'd0;
            d.tx_sh   = 8'd0;
        end else if (rise) begin
            d.rx_sh   = rx_full;
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                d.tx_sh = tx_byte_i;
            end
        end else if (fall && (q.bit_cnt != 3'd0)) begin
            d.tx_sh = {q.tx_sh[6:0], 1'b0};
        end
        miso_o = q.tx_sh[7] & ~cs_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_sync  <= '1;
            q.cs_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/spi_tl_regs.sv
// Register file, header decode, line buffer and packed-write sequencing.
module spi_tl_regs
    import spi_tl_pkg::*;
#(
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start_i,
    input  logic                    byte_done_i,
    input  logic [7:0]              rx_byte_i,
    input  logic                    fill_valid_i,
    input  logic [8*LINE_BYTES-1:0] fill_data_i,
    input  logic [1:0]              rd_stat_i,
    input  logic [1:0]              wr_stat_i,
    output logic [7:0]              tx_byte_o,
    output logic                    cmd_go_o,
    output logic [7:0]              cmd_code_o,
    output logic                    pack_go_o,
    output logic [8*ADDR_BYTES-1:0] addr_o,
    output logic [8*LINE_BYTES-1:0] line_o
);
    localparam int PTR_W    = $clog2(LINE_BYTES);
    localparam int AIW      = $clog2(ADDR_BYTES);
    localparam int PACK_LEN = ADDR_BYTES + LINE_BYTES;
    localparam int CNT_W    = $clog2(PACK_LEN + 1);

    typedef struct packed {
        logic                             in_hdr;
        logic                             is_wr;
        logic [6:0]                       cur;
        logic [PTR_W-1:0]                 ptr;
        logic [CNT_W-1:0]                 pack_cnt;
        logic [ADDR_BYTES-1:0][7:0]       addr;
        logic [15:0]                      len;
        logic [7:0]                       cmd;
        logic [LINE_BYTES-1:0][7:0]       lbuf;
        logic                             cmd_go;
        logic                             pack_go;
    } rg_t;

    rg_t q, d;
    logic [6:0]       na;
    logic [PTR_W-1:0] rp;
    logic             rd_en;
    logic [CNT_W-1:0] off;

    always_comb begin
        d         = q;
        d.cmd_go  = 1'b0;
        d.pack_go = 1'b0;
        na        = q.cur;
        rp        = q.ptr;
        rd_en     = 1'b0;
        off       = q.pack_cnt - CNT_W'(ADDR_BYTES);
        tx_byte_o = 8'd0;
        if (frame_start_i) begin
            d.in_hdr   = 1'b1;
            d.ptr      = '0;
            d.pack_cnt = '0;
        end else if (byte_done_i) begin
            if (q.in_hdr) begin
                d.in_hdr   = 1'b0;
                d.is_wr    = rx_byte_i[7];
                d.pack_cnt = '0;
                na         = rx_byte_i[6:0];
                rp         = '0;
                d.ptr      = '0;
                rd_en      = ~rx_byte_i[7];
            end else begin
                if (q.is_wr) begin
                    if (q.cur < 7'(ADDR_BYTES)) begin
                        d.addr[q.cur[AIW-1:0]] = rx_byte_i;
                    end else begin
                        case (q.cur)
                            REG_LEN_LO: d.len[7:0]  = rx_byte_i;
                            REG_LEN_HI: d.len[15:8] = rx_byte_i;
                            REG_CMD: begin
                                d.cmd    = rx_byte_i;
                                d.cmd_go = 1'b1;
                            end
                            REG_DATA: begin
                                d.lbuf[q.ptr] = rx_byte_i;
                                d.ptr         = q.ptr + PTR_W'(1);
                            end
                            REG_PACK: begin
                                if (q.pack_cnt < CNT_W'(ADDR_BYTES)) begin
                                    d.addr[q.pack_cnt[AIW-1:0]] = rx_byte_i;
                                end else if (q.pack_cnt < CNT_W'(PACK_LEN)) begin
                                    d.lbuf[off[PTR_W-1:0]] = rx_byte_i;
                                end
                                if (q.pack_cnt == CNT_W'(PACK_LEN - 1)) begin
                                    d.pack_go = 1'b1;
                                end
                                if (q.pack_cnt < CNT_W'(PACK_LEN)) begin
                                    d.pack_cnt = q.pack_cnt + CNT_W'(1);
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                na    = ((q.cur == REG_DATA) || (q.cur == REG_PACK)) ? q.cur : q.cur + 7'd1;
                rd_en = ~q.is_wr;
            end
            d.cur = na;
            if (rd_en) begin
                if (na < 7'(ADDR_BYTES)) begin
                    tx_byte_o = q.addr[na[AIW-1:0]];
                end else begin
                    case (na)
                        REG_LEN_LO:  tx_byte_o = q.len[7:0];
                        REG_LEN_HI:  tx_byte_o = q.len[15:8];
                        REG_CMD:     tx_byte_o = q.cmd;
                        REG_RD_STAT: tx_byte_o = {6'd0, rd_stat_i};
                        REG_WR_STAT: tx_byte_o = {6'd0, wr_stat_i};
                        REG_DATA: begin
                            tx_byte_o = q.lbuf[rp];
                            d.ptr     = rp + PTR_W'(1);
                        end
                        default:     tx_byte_o = 8'd0;
                    endcase
                end
            end
        end
        if (fill_valid_i) begin
            d.lbuf = fill_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_go_o   = q.cmd_go;
    assign cmd_code_o = q.cmd;
    assign pack_go_o  = q.pack_go;
    assign addr_o     = q.addr;
    assign line_o     = q.lbuf;

    // R9: a command write produces a launch strobe of exactly one cycle
    a_r9_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go_o |=> !cmd_go_o);
    // R7: a packed frame produces a single launch strobe
    a_r7_pack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pack_go_o |=> !pack_go_o);
endmodule

// File: rtl/spi_tl_host.sv
// Single-beat bus host: one request per accepted command, status tracking.
module spi_tl_host
    import spi_tl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SRC_W      = 4,
    parameter int SRC_ID     = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_go_i,
    input  logic [7:0]              cmd_code_i,
    input  logic                    pack_go_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [8*LINE_BYTES-1:0] line_i,
    output logic                    a_valid_o,
    input  logic                    a_ready_i,
    output logic [2:0]              a_opcode_o,
    output logic [2:0]              a_size_o,
    output logic [SRC_W-1:0]        a_source_o,
    output logic [ADDR_W-1:0]       a_address_o,
    output logic [LINE_BYTES-1:0]   a_mask_o,
    output logic [8*LINE_BYTES-1:0] a_data_o,
    input  logic                    d_valid_i,
    output logic                    d_ready_o,
    input  logic [2:0]              d_opcode_i,
    input  logic                    d_error_i,
    input  logic [8*LINE_BYTES-1:0] d_data_i,
    output logic                    fill_valid_o,
    output logic [8*LINE_BYTES-1:0] fill_data_o,
    output logic [1:0]              rd_stat_o,
    output logic [1:0]              wr_stat_o
);
    localparam int          OFF_W     = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);

    typedef struct packed {
        hstate_e                 st;
        logic                    is_rd;
        logic [ADDR_W-1:0]       addr;
        logic [8*LINE_BYTES-1:0] data;
        stat_e                   rd_stat;
        stat_e                   wr_stat;
    } hs_t;

    hs_t q, d;
    logic launch_rd, launch_wr, resp_ok;

    always_comb begin
        d            = q;
        fill_valid_o = 1'b0;
        launch_rd    = cmd_go_i && (cmd_code_i == CMD_READ);
        launch_wr    = (cmd_go_i && (cmd_code_i == CMD_WRITE)) || pack_go_i;
        resp_ok      = !d_error_i &&
                       (d_opcode_i == (q.is_rd ? OP_ACK_DATA : OP_ACK));
        case (q.st)
            H_IDLE: begin
                if (launch_rd || launch_wr) begin
                    d.st    = H_REQ;
                    d.is_rd = launch_rd;
                    d.addr  = addr_i & ALIGN_MASK;
                    d.data  = line_i;
                    if (launch_rd) d.rd_stat = ST_BUSY;
                    else           d.wr_stat = ST_BUSY;
                end
            end
            H_REQ: begin
                if (a_ready_i) d.st = H_RESP;
            end
            H_RESP: begin
                if (d_valid_i) begin
                    d.st = H_HOLD;
                    if (q.is_rd) d.rd_stat = resp_ok ? ST_DONE : ST_ERROR;
                    else         d.wr_stat = resp_ok ? ST_DONE : ST_ERROR;
                    fill_valid_o = q.is_rd && resp_ok;
                end
            end
            H_HOLD: begin
                if (cmd_go_i && (cmd_code_i == CMD_NULL)) begin
                    d.st      = H_IDLE;
                    d.rd_stat = ST_IDLE;
                    d.wr_stat = ST_IDLE;
                end
            end
            default: d.st = H_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= H_IDLE;
            q.rd_stat <= ST_IDLE;
            q.wr_stat <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign a_valid_o   = (q.st == H_REQ);
    assign a_opcode_o  = q.is_rd ? OP_GET : OP_PUT_FULL;
    assign a_size_o    = 3'(OFF_W);
    assign a_source_o  = SRC_W'(SRC_ID);
    assign a_address_o = q.addr;
    assign a_mask_o    = '1;
    assign a_data_o    = q.data;
    assign d_ready_o   = (q.st == H_RESP);
    assign fill_data_o = d_data_i;
    assign rd_stat_o   = q.rd_stat;
    assign wr_stat_o   = q.wr_stat;

    // R5: a waiting request holds its opcode and address
    a_r5_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid_o && !a_ready_i |=> a_valid_o && $stable(a_address_o) && $stable(a_opcode_o));
    // R12: never both statuses active
    a_r12_one_active: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_stat_o != ST_IDLE) && (wr_stat_o != ST_IDLE)));
    // R6: read done is entered only right after a response handshake
    a_r6_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_o == ST_DONE) && ($past(rd_stat_o) != ST_DONE) |-> $past(d_valid_i && d_ready_o));
    // R9: a completed read status clears only through the null command
    a_r9_clear_by_null: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(rd_stat_o) == ST_DONE) || ($past(rd_stat_o) == ST_ERROR)) && (rd_stat_o == ST_IDLE)
        |-> $past(cmd_go_i && (cmd_code_i == CMD_NULL)));
endmodule

// File: rtl/spi_tl_bridge.sv
module spi_tl_bridge
    import spi_tl_pkg::*;
#(
    parameter int LINE_BYTES  = 16,
    parameter int SRC_W       = 4,
    parameter int SRC_ID      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck_i,
    input  logic                    spi_csb_i,
    input  logic                    spi_mosi_i,
    output logic                    spi_miso_o,
    output logic                    tl_a_valid_o,
    input  logic                    tl_a_ready_i,
    output logic [2:0]              tl_a_opcode_o,
    output logic [2:0]              tl_a_size_o,
    output logic [SRC_W-1:0]        tl_a_source_o,
    output logic [31:0]             tl_a_address_o,
    output logic [LINE_BYTES-1:0]   tl_a_mask_o,
    output logic [8*LINE_BYTES-1:0] tl_a_data_o,
    input  logic                    tl_d_valid_i,
    output logic                    tl_d_ready_o,
    input  logic [2:0]              tl_d_opcode_i,
    input  logic                    tl_d_error_i,
    input  logic [8*LINE_BYTES-1:0] tl_d_data_i
);
    localparam int ADDR_W = 8 * ADDR_BYTES;

    logic                    frame_start, byte_done, cmd_go, pack_go, fill_valid;
    logic [7:0]              rx_byte, tx_byte, cmd_code;
    logic [ADDR_W-1:0]       addr;
    logic [8*LINE_BYTES-1:0] line, fill_data;
    logic [1:0]              rd_stat, wr_stat;

    spi_tl_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sck_i(spi_sck_i), .csb_i(spi_csb_i), .mosi_i(spi_mosi_i),
        .tx_byte_i(tx_byte), .miso_o(spi_miso_o),
        .frame_start_o(frame_start), .byte_done_o(byte_done), .rx_byte_o(rx_byte)
    );

    spi_tl_regs #(.LINE_BYTES(LINE_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .frame_start_i(frame_start), .byte_done_i(byte_done), .rx_byte_i(rx_byte),
        .fill_valid_i(fill_valid), .fill_data_i(fill_data),
        .rd_stat_i(rd_stat), .wr_stat_i(wr_stat),
        .tx_byte_o(tx_byte), .cmd_go_o(cmd_go), .cmd_code_o(cmd_code),
        .pack_go_o(pack_go), .addr_o(addr), .line_o(line)
    );

    spi_tl_host #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SRC_W(SRC_W), .SRC_ID(SRC_ID)
    ) u_host (
        .clk(clk), .rst_n(rst_n),
        .cmd_go_i(cmd_go), .cmd_code_i(cmd_code), .pack_go_i(pack_go),
        .addr_i(addr), .line_i(line),
        .a_valid_o(tl_a_valid_o), .a_ready_i(tl_a_ready_i),
        .a_opcode_o(tl_a_opcode_o), .a_size_o(tl_a_size_o),
        .a_source_o(tl_a_source_o), .a_address_o(tl_a_address_o),
        .a_mask_o(tl_a_mask_o), .a_data_o(tl_a_data_o),
        .d_valid_i(tl_d_valid_i), .d_ready_o(tl_d_ready_o),
        .d_opcode_i(tl_d_opcode_i), .d_error_i(tl_d_error_i), .d_data_i(tl_d_data_i),
        .fill_valid_o(fill_valid), .fill_data_o(fill_data),
        .rd_stat_o(rd_stat), .wr_stat_o(wr_stat)
    );
endmodule

// File: tb/spi_tl_bridge_bench.sv
module spi_tl_bridge_bench;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csb = 1'b1, mosi = 1'b0;
    logic miso;
    logic a_valid, a_ready = 1'b0, d_valid = 1'b0, d_ready, d_error = 1'b0;
    logic [2:0] a_opcode, a_size, d_opcode = 3'd0;
    logic [3:0] a_source;
    logic [31:0] a_address;
    logic [15:0] a_mask;
    logic [127:0] a_data, d_data = '0;

    always #2.5 clk = ~clk;

    spi_tl_bridge u_spi_tl_bridge (
        .clk(clk), .rst_n(rst_n),
        .spi_sck_i(sck), .spi_csb_i(csb), .spi_mosi_i(mosi), .spi_miso_o(miso),
        .tl_a_valid_o(a_valid), .tl_a_ready_i(a_ready), .tl_a_opcode_o(a_opcode),
        .tl_a_size_o(a_size), .tl_a_source_o(a_source), .tl_a_address_o(a_address),
        .tl_a_mask_o(a_mask), .tl_a_data_o(a_data),
        .tl_d_valid_i(d_valid), .tl_d_ready_o(d_ready), .tl_d_opcode_i(d_opcode),
        .tl_d_error_i(d_error), .tl_d_data_i(d_data)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    // device model state
    logic [127:0] mem [16];
    int ready_dly = 0;
    bit err_inj = 0, bad_op = 0;
    int req_cnt = 0;
    logic [2:0] last_op, last_size;
    logic [31:0] last_addr;
    logic [15:0] last_mask;
    logic [127:0] last_data;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : device
        forever begin
            @(negedge clk);
            if (a_valid) begin
                int dly;
                dly = (ready_dly > 0) ? ready_dly : int'($urandom_range(0, 3));
                repeat (dly) @(negedge clk);
                a_ready   = 1'b1;
                last_op   = a_opcode;
                last_size = a_size;
                last_addr = a_address;
                last_mask = a_mask;
                last_data = a_data;
                req_cnt++;
                @(negedge clk);
                a_ready = 1'b0;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                d_valid = 1'b1;
                d_error = err_inj;
                if (last_op == 3'd4) begin
                    d_opcode = bad_op ? 3'd2 : 3'd1;
                    d_data   = mem[last_addr[7:4]];
                end else begin
                    d_opcode = bad_op ? 3'd1 : 3'd0;
                    d_data   = $urandom();
                    if (!err_inj && !bad_op) mem[last_addr[7:4]] = last_data;
                end
                while (!d_ready) @(negedge clk);
                @(negedge clk);
                d_valid = 1'b0;
            end
        end
    end

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic spi_open();
        csb = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_close();
        repeat (HALF) @(negedge clk);
        csb = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] v);
        logic [7:0] r;
        spi_open();
        spi_byte({1'b1, a}, r);
        spi_byte(v, r);
        spi_close();
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] v);
        logic [7:0] r;
        spi_open();
        spi_byte({1'b0, a}, r);
        spi_byte(8'h00, v);
        spi_close();
    endtask

    task automatic set_addr(input logic [31:0] ad);
        logic [7:0] r;
        spi_open();
        spi_byte(8'h80, r);
        for (int i = 0; i < 4; i++) spi_byte(ad[8*i +: 8], r);
        spi_close();
    endtask

    task automatic rd_line(output logic [127:0] ln);
        logic [7:0] r;
        spi_open();
        spi_byte(8'h09, r);
        for (int i = 0; i < 16; i++) begin
            spi_byte(8'h00, r);
            ln[8*i +: 8] = r;
        end
        spi_close();
    endtask

    task automatic wr_buf(input logic [127:0] ln);
        logic [7:0] r;
        spi_open();
        spi_byte(8'h89, r);
        for (int i = 0; i < 16; i++) spi_byte(ln[8*i +: 8], r);
        spi_close();
    endtask

    task automatic pack_write(input logic [31:0] ad, input logic [127:0] ln);
        logic [7:0] r;
        spi_open();
        spi_byte(8'h8A, r);
        for (int i = 0; i < 4; i++) spi_byte(ad[8*i +: 8], r);
        for (int i = 0; i < 16; i++) spi_byte(ln[8*i +: 8], r);
        spi_close();
    endtask

    task automatic wait_stat(input logic [6:0] a, output logic [7:0] v);
        for (int i = 0; i < 40; i++) begin
            rd_reg(a, v);
            if (v != 8'd1) break;
        end
    endtask

    function automatic logic [127:0] rnd_line();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, r;
        logic [127:0] ln, l2, got;
        logic [31:0] ad;
        int n0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 16; i++) mem[i] = rnd_line();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state at the ports and in all registers
        chk("R1 miso", miso, 0);
        chk("R1 a_valid", a_valid, 0);
        spi_open();
        spi_byte(8'h00, r);
        for (int i = 0; i < 9; i++) begin
            spi_byte(8'h00, v);
            chk("R1 reg reset", v, 0);
        end
        spi_close();

        // R2: address bytes, LSB first, auto-increment readback
        set_addr(32'h1234_5678);
        spi_open();
        spi_byte(8'h00, r);
        for (int i = 0; i < 4; i++) begin
            spi_byte(8'h00, v);
            chk("R2 addr byte", v, 32'h1234_5678 >> (8 * i) & 32'hFF);
        end
        spi_close();

        // R3: length register readback
        wr_reg(7'h04, 8'hEF);
        wr_reg(7'h05, 8'hBE);
        rd_reg(7'h04, v); chk("R3 len lo", v, 8'hEF);
        rd_reg(7'h05, v); chk("R3 len hi", v, 8'hBE);

        // R4 / R6: read of an unaligned address
        ln = mem[2];
        set_addr(32'h1000_0025);
        wr_reg(7'h06, 8'h01);
        wait_stat(7'h07, v);
        chk("R6 rd status done", v, 2);
        chk("R4 opcode get", last_op, 4);
        chk("R4 aligned address", last_addr, 32'h1000_0020);
        chk("R4 mask", last_mask, 16'hFFFF);
        chk("R3 size fixed", last_size, 4);
        rd_line(got);
        chk("R6 bulk data", got, ln);
        rd_line(got);
        chk("R6 pointer restarts", got, ln);

        // R10: command while done is ignored
        n0 = req_cnt;
        wr_reg(7'h06, 8'h02);
        repeat (40) @(negedge clk);
        chk("R10 no new request", req_cnt, n0);
        rd_reg(7'h08, v); chk("R10 wr status unchanged", v, 0);
        rd_reg(7'h07, v); chk("R10 rd status held", v, 2);

        // R9: null clears
        wr_reg(7'h06, 8'h00);
        rd_reg(7'h07, v); chk("R9 cleared", v, 0);

        // R8: error response leaves buffer unchanged
        err_inj = 1;
        set_addr(32'h1000_0050);
        wr_reg(7'h06, 8'h01);
        wait_stat(7'h07, v);
        chk("R8 error status", v, 3);
        rd_line(got); chk("R8 buffer kept", got, ln);
        err_inj = 0;
        wr_reg(7'h06, 8'h00);
        rd_reg(7'h07, v); chk("R9 clear after error", v, 0);
        bad_op = 1;
        wr_reg(7'h06, 8'h01);
        wait_stat(7'h07, v);
        chk("R8 bad opcode", v, 3);
        rd_line(got); chk("R8 buffer kept opcode", got, ln);
        bad_op = 0;
        wr_reg(7'h06, 8'h00);

        // R11: write from buffer via command 0x02
        l2 = rnd_line();
        wr_buf(l2);
        set_addr(32'h2000_0070);
        wr_reg(7'h06, 8'h02);
        wait_stat(7'h08, v);
        chk("R11 wr status", v, 2);
        chk("R11 opcode put", last_op, 0);
        chk("R11 data", last_data, l2);
        chk("R11 memory", mem[7], l2);
        wr_reg(7'h06, 8'h00);

        // R10 / R12: commands while busy
        ready_dly = 1500;
        n0 = req_cnt;
        set_addr(32'h3000_0030);
        wr_reg(7'h06, 8'h01);
        rd_reg(7'h07, v); chk("R10 busy status", v, 1);
        wr_reg(7'h06, 8'h02);
        wr_reg(7'h06, 8'h00);
        rd_reg(7'h08, v); chk("R12 wr idle while read busy", v, 0);
        wait_stat(7'h07, v);
        ready_dly = 0;
        chk("R10 read completes", v, 2);
        chk("R10 single request", req_cnt, n0 + 1);
        rd_reg(7'h08, v); chk("R10 write ignored", v, 0);
        wr_reg(7'h06, 8'h00);

        // R7 / R6: random packed writes and readback
        for (int it = 0; it < 8; it++) begin
            ad = $urandom();
            ln = rnd_line();
            pack_write(ad, ln);
            wait_stat(7'h08, v);
            chk("R7 wr done", v, 2);
            chk("R7 opcode put", last_op, 0);
            chk("R7 address", last_addr, {ad[31:4], 4'h0});
            chk("R7 mask", last_mask, 16'hFFFF);
            chk("R7 data", last_data, ln);
            wr_reg(7'h06, 8'h00);
            wr_reg(7'h06, 8'h01);
            wait_stat(7'h07, v);
            chk("R6 rd done", v, 2);
            rd_line(got);
            chk("R6 readback", got, ln);
            wr_reg(7'h06, 8'h00);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule